// File: doc/BRIEF.md
# Trigger-Staged Control Register Bank with Power Modes

This block is the register bank that sits behind a serial control front end. It receives single-byte register writes and reads on a simple parallel bus and returns read data one cycle later. From its registers it drives the enables of a ten-way switch: exactly one port enable is high, or none is high and the isolation flag is set. The bank holds a switch control byte, a group identifier, a power-mode and trigger byte, two fixed identification bytes, and a byte that carries the rewritable unique slave identifier.

The switch control byte has two copies. A write lands in a staged copy, and a trigger strobe copies the staged value into the live copy that feeds the port decoder. Each trigger has its own mask bit. When every trigger is masked, a write goes straight to the live copy. The power-mode field gates the switch: in low power the switch is isolated. Writing the startup code restores every register to its reset value. Writes flagged as broadcast are accepted only by the power-mode and trigger byte.

Top module: `crb_regbank`

## Requirements
- R1: After synchronous reset, `pwr_mode` is 2'b10, `port_en` is 0 and `iso` is 1. Reads return 0x00 from address 0x00, 0x00 from 0x1B, 0x80 from 0x1C and 0x3A from 0x1F.
- R2: A non-broadcast write to address 0x00 while any trigger mask is clear updates only the staged copy. Reads of 0x00 return the live copy, and the switch outputs do not change.
- R3: In address 0x1C, bit 0 is trigger 0 and the mask bits are bit 3 (trigger 0), bit 4 (trigger 1) and bit 5 (trigger 2). Writing 0x1C with bit 0 set while the stored trigger-0 mask is clear copies the staged byte into the live copy. Bits 2:0 of 0x1C always read 0.
- R4: While the stored masks (bits 5:3 of 0x1C) are all 1, a write to 0x00 updates the live copy and the staged copy together.
- R5: A trigger-0 write does not copy when the stored trigger-0 mask is set.
- R6: With power mode 2'b00, live bits 6:4 equal to 0 and bit 7 ignored, live bits 3:0 select the enabled port: 0010 port1 (`port_en[0]`), 1010 port2, 1110 port3, 1011 port4, 0001 port5, 1001 port6, 0110 port7, 0100 port8, 1100 port9, 1000 port10 (`port_en[9]`). Every other value gives `port_en` 0 with `iso` 1. The outputs follow a change in the live copy or the power mode one clock later.
- R7: Power-mode field bits 7:6 of 0x1C: 2'b10 (low power) forces isolation, and writing 2'b11 leaves the stored mode unchanged while the mask bits still update.
- R8: Writing 2'b01 to bits 7:6 of 0x1C restores every register to its R1 value, including both copies of the switch byte. The other bits of that write are ignored.
- R9: A write with `bus_bcast` high is accepted only at address 0x1C. At any other address it changes nothing.
- R10: Address 0x1D reads 0x01 and 0x1E reads 0x81. Address 0x1F reads {2'b00, 2'b11, id}, where id is the writable 4-bit unique ID. Address 0x1B reads {4'h0, group id}.
- R11: Reads of any other address return 0x00, and writes to them change no register.
- R12: `bus_rdata` presents the addressed register one clock after `bus_rd` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe |
| bus_bcast | input | 1 | Write arrived through the broadcast identifier |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| port_en | output | 10 | One-hot switch port enables |
| iso | output | 1 | Isolation flag, high when no port is enabled |
| pwr_mode | output | 2 | Stored power-mode field |

## Verification
A register write takes effect at the clock edge that samples the strobe. Register readback is therefore due one edge after the read strobe. The switch outputs are due one edge after the write, because the port decoder has its own register. The bench drives strobes on the falling edge. After each write it waits one further falling edge before comparing `port_en` and `iso` against a model updated at the write edge. Each read is compared at the falling edge that follows its sampling edge.

// File: rtl/crb_pkg.sv
`timescale 1ns/1ps
package crb_pkg;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int NTRIG = 3;
  localparam int NPORT = 10;

  localparam logic [AW-1:0] A_SW  = 5'h00;
  localparam logic [AW-1:0] A_GRP = 5'h1B;
  localparam logic [AW-1:0] A_PMT = 5'h1C;
  localparam logic [AW-1:0] A_PID = 5'h1D;
  localparam logic [AW-1:0] A_MID = 5'h1E;
  localparam logic [AW-1:0] A_UID = 5'h1F;

  typedef enum logic [1:0] {
    PM_ACTIVE  = 2'b00,
    PM_STARTUP = 2'b01,
    PM_LOWPWR  = 2'b10,
    PM_RSVD    = 2'b11
  } pm_e;

  // Select code per port, port1 in the lowest nibble
  localparam logic [4*NPORT-1:0] CODE_TBL = 40'h8C4691BEA2;
endpackage

// File: rtl/crb_cfg_regs.sv
`timescale 1ns/1ps
module crb_cfg_regs
  import crb_pkg::*;
#(
  parameter int AW_P = AW,
  parameter int DW_P = DW,
  parameter int NTRIG_P = NTRIG,
  parameter logic [3:0] USID_RST = 4'hA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              bcast,
  input  logic [AW_P-1:0]   addr,
  input  logic [DW_P-1:0]   wdata,
  output logic [3:0]        gsid,
  output logic [3:0]        usid,
  output logic [1:0]        pm,
  output logic [NTRIG_P-1:0] mask,
  output logic              sw_wr,
  output logic              sw_direct,
  output logic [NTRIG_P-1:0] trig_fire,
  output logic              soft_rst
);
  localparam int MASK_LO = 3;

  logic acc, pmt_wr;

  always_comb begin
    acc       = wr && (!bcast || addr == A_PMT);
    pmt_wr    = acc && (addr == A_PMT);
    sw_wr     = acc && (addr == A_SW);
    sw_direct = sw_wr && (&mask);
    soft_rst  = pmt_wr && (wdata[7:6] == PM_STARTUP);
  end

  for (genvar t = 0; t < NTRIG_P; t++) begin : g_trig
    assign trig_fire[t] = pmt_wr && !soft_rst && wdata[t] && !mask[t];
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      gsid <= '0;
      usid <= USID_RST;
      pm   <= PM_LOWPWR;
      mask <= '0;
    end else begin
      if (acc && addr == A_GRP) gsid <= wdata[3:0];
      if (acc && addr == A_UID) usid <= wdata[3:0];
      if (pmt_wr) begin
        mask <= wdata[MASK_LO +: NTRIG_P];
        if (wdata[7:6] != PM_RSVD) pm <= wdata[7:6];
      end
    end
  end
endmodule

// File: rtl/crb_trig_stage.sv
`timescale 1ns/1ps
module crb_trig_stage #(
  parameter int DW_P = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            ld,
  input  logic            direct,
  input  logic            fire,
  input  logic [DW_P-1:0] din,
  output logic [DW_P-1:0] staged,
  output logic [DW_P-1:0] live
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      staged <= '0;
      live   <= '0;
    end else begin
      if (ld) staged <= din;
      if (ld && direct) live <= din;
      else if (fire)    live <= staged;
    end
  end
endmodule

// File: rtl/crb_port_decode.sv
`timescale 1ns/1ps
module crb_port_decode
  import crb_pkg::*;
#(
  parameter int DW_P = DW,
  parameter int NPORT_P = NPORT,
  parameter logic [4*NPORT_P-1:0] TBL = CODE_TBL
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         pm,
  input  logic [DW_P-1:0]    code,
  output logic [NPORT_P-1:0] port_en,
  output logic               iso
);
  logic en;
  logic [NPORT_P-1:0] hit;

  assign en = (pm == PM_ACTIVE) && (code[6:4] == 3'b000);

  for (genvar p = 0; p < NPORT_P; p++) begin : g_port
    assign hit[p] = en && (code[3:0] == TBL[4*p +: 4]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_en <= '0;
      iso     <= 1'b1;
    end else begin
      port_en <= hit;
      iso     <= ~|hit;
    end
  end
endmodule

// File: rtl/crb_read_mux.sv
`timescale 1ns/1ps
module crb_read_mux
  import crb_pkg::*;
#(
  parameter int AW_P = AW,
  parameter int DW_P = DW,
  parameter int NTRIG_P = NTRIG,
  parameter logic [7:0] PROD_ID = 8'h01,
  parameter logic [7:0] MFR_LO  = 8'h81,
  parameter logic [1:0] MFR_HI  = 2'b11
) (
  input  logic [AW_P-1:0]    addr,
  input  logic [DW_P-1:0]    live,
  input  logic [3:0]         gsid,
  input  logic [3:0]         usid,
  input  logic [1:0]         pm,
  input  logic [NTRIG_P-1:0] mask,
  output logic [DW_P-1:0]    rdata
);
  always_comb begin
    case (addr)
      A_SW:    rdata = live;
      A_GRP:   rdata = {4'h0, gsid};
      A_PMT:   rdata = {pm, mask, {NTRIG_P{1'b0}}};
      A_PID:   rdata = PROD_ID;
      A_MID:   rdata = MFR_LO;
      A_UID:   rdata = {2'b00, MFR_HI, usid};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/crb_regbank.sv
`timescale 1ns/1ps
module crb_regbank
  import crb_pkg::*;
#(
  parameter int AW_P = AW,
  parameter int DW_P = DW,
  parameter int NPORT_P = NPORT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic               bus_bcast,
  input  logic [AW_P-1:0]    bus_addr,
  input  logic [DW_P-1:0]    bus_wdata,
  output logic [DW_P-1:0]    bus_rdata,
  output logic [NPORT_P-1:0] port_en,
  output logic               iso,
  output logic [1:0]         pwr_mode
);
  logic [3:0] gsid, usid;
  logic [NTRIG-1:0] mask, trig_fire;
  logic sw_wr, sw_direct, soft_rst;
  logic [DW_P-1:0] staged, live, rd_comb;

  crb_cfg_regs #(.AW_P(AW_P), .DW_P(DW_P), .NTRIG_P(NTRIG)) u_cfg (
    .clk(clk), .rst(rst), .wr(bus_wr), .bcast(bus_bcast),
    .addr(bus_addr), .wdata(bus_wdata),
    .gsid(gsid), .usid(usid), .pm(pwr_mode), .mask(mask),
    .sw_wr(sw_wr), .sw_direct(sw_direct), .trig_fire(trig_fire),
    .soft_rst(soft_rst)
  );

  // Switch control byte belongs to trigger 0
  crb_trig_stage #(.DW_P(DW_P)) u_sw (
    .clk(clk), .rst(rst), .clr(soft_rst), .ld(sw_wr), .direct(sw_direct),
    .fire(trig_fire[0]), .din(bus_wdata), .staged(staged), .live(live)
  );

  crb_port_decode #(.DW_P(DW_P), .NPORT_P(NPORT_P)) u_dec (
    .clk(clk), .rst(rst), .pm(pwr_mode), .code(live),
    .port_en(port_en), .iso(iso)
  );

  crb_read_mux #(.AW_P(AW_P), .DW_P(DW_P), .NTRIG_P(NTRIG)) u_rmux (
    .addr(bus_addr), .live(live), .gsid(gsid), .usid(usid),
    .pm(pwr_mode), .mask(mask), .rdata(rd_comb)
  );

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_comb;
  end
endmodule

// File: rtl/crb_regbank_chk.sv
`timescale 1ns/1ps
module crb_regbank_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       bus_bcast,
  input logic [4:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [9:0] port_en,
  input logic       iso,
  input logic [1:0] pwr_mode,
  input logic [3:0] usid
);
  logic unmapped;
  assign unmapped = !(bus_addr inside {5'h00, 5'h1B, 5'h1C, 5'h1D, 5'h1E, 5'h1F});

  AST_RESET_LOWPWR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pwr_mode == 2'b10); // R1
  AST_PORT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(port_en)); // R6
  AST_ISO_NO_PORT: assert property (@(posedge clk) disable iff (rst)
    iso == (port_en == '0)); // R6
  AST_LOWPWR_ISOLATES: assert property (@(posedge clk) disable iff (rst)
    $past(pwr_mode) == 2'b10 |-> iso); // R7
  AST_TRIG_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == 5'h1C) |-> bus_rdata[2:0] == 3'b000); // R3
  AST_PROD_ID_FIXED: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == 5'h1D) |-> bus_rdata == 8'h01); // R10
  AST_BCAST_USID_KEPT: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_bcast && bus_addr == 5'h1F) |=> $stable(usid)); // R9
  AST_STARTUP_RESTORES: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 5'h1C && bus_wdata[7:6] == 2'b01) |=> pwr_mode == 2'b10); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && unmapped) |-> bus_rdata == 8'h00); // R11
endmodule

bind crb_regbank crb_regbank_chk u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_bcast(bus_bcast),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .port_en(port_en), .iso(iso), .pwr_mode(pwr_mode), .usid(usid)
);

// File: tb/sim_crb_regbank.sv
`timescale 1ns/1ps
module sim_crb_regbank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_bcast = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [9:0] port_en;
  logic iso;
  logic [1:0] pwr_mode;

  int checks = 0;
  int errors = 0;

  // model state
  logic [7:0] m_sh, m_act;
  logic [3:0] m_gsid, m_usid;
  logic [1:0] m_pm;
  logic [2:0] m_mask;

  always #10 clk = ~clk;

  crb_regbank u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_bcast(bus_bcast),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .port_en(port_en), .iso(iso), .pwr_mode(pwr_mode)
  );

  function automatic void m_defaults();
    m_sh = 8'h00; m_act = 8'h00; m_gsid = 4'h0; m_usid = 4'hA;
    m_pm = 2'b10; m_mask = 3'b000;
  endfunction

  function automatic void m_write(input logic [4:0] a, input logic [7:0] d, input logic bc);
    if (bc && a != 5'h1C) return;
    case (a)
      5'h00: begin
        if (m_mask == 3'b111) m_act = d;
        m_sh = d;
      end
      5'h1B: m_gsid = d[3:0];
      5'h1F: m_usid = d[3:0];
      5'h1C: begin
        if (d[7:6] == 2'b01) m_defaults();
        else begin
          if (d[0] && !m_mask[0]) m_act = m_sh;
          if (d[7:6] != 2'b11) m_pm = d[7:6];
          m_mask = d[5:3];
        end
      end
      default: ;
    endcase
  endfunction

  function automatic logic [7:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return m_act;
      5'h1B: return {4'h0, m_gsid};
      5'h1C: return {m_pm, m_mask, 3'b000};
      5'h1D: return 8'h01;
      5'h1E: return 8'h81;
      5'h1F: return {4'b0011, m_usid};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [9:0] m_ports();
    int n;
    if (m_pm != 2'b00 || m_act[6:4] != 3'b000) return '0;
    case (m_act[3:0])
      4'b0010: n = 1;  4'b1010: n = 2;  4'b1110: n = 3;  4'b1011: n = 4;
      4'b0001: n = 5;  4'b1001: n = 6;  4'b0110: n = 7;  4'b0100: n = 8;
      4'b1100: n = 9;  4'b1000: n = 10;
      default: n = 0;
    endcase
    return (n == 0) ? 10'd0 : (10'd1 << (n - 1));
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [4:0] a, input logic [7:0] d, input logic bc);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_bcast = bc;
    @(posedge clk);
    m_write(a, d, bc);
    @(negedge clk);
    bus_wr = 1'b0; bus_bcast = 1'b0;
  endtask

  task automatic brd(input string req, input logic [4:0] a);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, {8'h00, bus_rdata}, {8'h00, m_read(a)});
  endtask

  task automatic chk_ports(input string req);
    @(negedge clk);
    chk(req, {6'h0, port_en}, {6'h0, m_ports()});
    chk(req, {15'h0, iso}, {15'h0, (m_ports() == 10'd0)});
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_defaults();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwr_mode", {14'h0, pwr_mode}, 16'h0002);
    chk("R1 ports", {6'h0, port_en}, 16'h0000);
    chk("R1 iso", {15'h0, iso}, 16'h0001);
    brd("R1 sw", 5'h00); brd("R1 grp", 5'h1B); brd("R1 pmt", 5'h1C); brd("R1 uid", 5'h1F);

    // R2 staged write only
    bwr(5'h1C, 8'h00, 1'b0);
    bwr(5'h00, 8'h02, 1'b0);
    chk_ports("R2 outputs unchanged");
    brd("R2 live readback", 5'h00);
    // R3 trigger 0 copies
    bwr(5'h1C, 8'h01, 1'b0);
    chk_ports("R3 trigger copies");
    chk("R3 port1", {6'h0, port_en}, 16'h0001);
    brd("R3 trig bits zero", 5'h1C);
    // R5 masked trigger
    bwr(5'h1C, 8'h08, 1'b0);
    bwr(5'h00, 8'h0A, 1'b0);
    bwr(5'h1C, 8'h09, 1'b0);
    chk_ports("R5 masked no copy");
    chk("R5 still port1", {6'h0, port_en}, 16'h0001);
    // R4 all masked goes direct
    bwr(5'h1C, 8'h38, 1'b0);
    bwr(5'h00, 8'h0E, 1'b0);
    chk_ports("R4 direct write");
    chk("R4 port3", {6'h0, port_en}, 16'h0004);
    // R6 full code sweep
    for (int v = 0; v < 256; v++) begin
      bwr(5'h00, v[7:0], 1'b0);
      chk_ports("R6 decode");
    end
    // R7 low power and reserved mode
    bwr(5'h00, 8'h01, 1'b0);
    bwr(5'h1C, 8'hB8, 1'b0);
    chk_ports("R7 lowpower iso");
    chk("R7 iso", {15'h0, iso}, 16'h0001);
    bwr(5'h1C, 8'hE0, 1'b0);
    brd("R7 reserved keeps mode", 5'h1C);
    // R9 broadcast
    bwr(5'h1C, 8'h38, 1'b0);
    bwr(5'h1F, 8'h05, 1'b1);
    brd("R9 bcast uid ignored", 5'h1F);
    bwr(5'h00, 8'h08, 1'b1);
    chk_ports("R9 bcast sw ignored");
    brd("R9 bcast sw readback", 5'h00);
    bwr(5'h1B, 8'h06, 1'b1);
    brd("R9 bcast grp ignored", 5'h1B);
    bwr(5'h1C, 8'h28, 1'b1);
    brd("R9 bcast pmt accepted", 5'h1C);
    // R10 ids
    bwr(5'h1B, 8'hF7, 1'b0);
    brd("R10 grp", 5'h1B);
    bwr(5'h1F, 8'hC5, 1'b0);
    brd("R10 uid", 5'h1F);
    brd("R10 pid", 5'h1D);
    brd("R10 mid", 5'h1E);
    // R11 unmapped
    bwr(5'h05, 8'hFF, 1'b0);
    bwr(5'h1D, 8'h55, 1'b0);
    brd("R11 unmapped read", 5'h05);
    brd("R11 id unchanged", 5'h1D);
    brd("R11 sw unchanged", 5'h00);
    // R8 startup restores
    bwr(5'h1C, 8'h38, 1'b0);
    bwr(5'h00, 8'h0E, 1'b0);
    bwr(5'h1C, 8'h7F, 1'b0);
    chk_ports("R8 ports after startup");
    chk("R8 pwr_mode", {14'h0, pwr_mode}, 16'h0002);
    brd("R8 sw", 5'h00); brd("R8 grp", 5'h1B); brd("R8 pmt", 5'h1C); brd("R8 uid", 5'h1F);
    bwr(5'h1C, 8'h01, 1'b0);
    brd("R8 staged cleared", 5'h00);
    // random mix, R12 read timing
    for (int i = 0; i < 400; i++) begin
      logic [4:0] a;
      logic [7:0] d;
      logic bc;
      case ($urandom % 8)
        0, 1:    a = 5'h00;
        2, 3:    a = 5'h1C;
        4:       a = 5'h1B;
        5:       a = 5'h1F;
        6:       a = 5'h1D;
        default: a = 5'($urandom);
      endcase
      d = 8'($urandom);
      if (a == 5'h1C && d[7:6] == 2'b01 && ($urandom % 4 != 0)) d[7:6] = 2'b00;
      if (a == 5'h00 && ($urandom % 2 == 0)) d[6:4] = 3'b000;
      bc = ($urandom % 8 == 0);
      bwr(a, d, bc);
      chk_ports("R6 random ports");
      brd("R12 random read", 5'($urandom));
    end
    summary();
  end
endmodule